// File: doc/BRIEF.md
# Reservation Station Issue Pool

This block is the waiting room between in-order dispatch and the out-of-order execution units of a small integer core. Each cycle, dispatch may hand it one instruction: an opaque opcode, the execution unit class it belongs to, the reorder-buffer tag of its destination, and two source operands. Each operand arrives either as a finished value or as the tag of a result still in flight. The pool has four slots. When no slot is free it raises a full signal, and dispatch must hold.

Every execution unit drives its own result bus with a valid bit, a tag and a value. A slot whose operand is still pending watches all four buses. On a tag match it takes the value at the clock edge, and the slot can issue from the next cycle on. An instruction that waits on a result being broadcast in its own dispatch cycle takes that value as it is written into its slot.

There is one issue port for each unit: adder, multiplier, divider and memory. In a cycle, each unit takes the oldest slot that is ready and aimed at it, provided the unit reports that it can accept work. Up to four instructions can leave in one cycle, and a slot is released at the edge where its instruction issues. A flush input empties the pool at once.

Top module: `rsPool`

## Requirements
- R1: The pool holds four instructions. `dispFull` is high exactly when all four slots are occupied, and a dispatch presented while `dispFull` is high is dropped.
- R2: The unit class code on `dispUnit` is 0 for the adder (set, add, sub, branches, ret), 1 for the multiplier, 2 for the divider and 3 for memory. An instruction leaves only through the issue port with the same index as its class.
- R3: An instruction issues only when both of its operands are available and `unitReady` is high for its unit. Until then it stays in its slot and its issue port shows `issValid` low.
- R4: In one cycle, up to four instructions aimed at four different units can issue together, with at most one per unit.
- R5: When several ready instructions target the same unit, they issue one per cycle in dispatch order, whichever slots they occupy.
- R6: A slot is freed at the clock edge where its instruction issues, and a new dispatch may reuse it in the next cycle.
- R7: A pending operand whose tag equals the tag of a valid broadcast captures that bus's data at the clock edge. The instruction is ready no earlier than the cycle after the broadcast.
- R8: A dispatched operand that is pending on a tag being broadcast in the same cycle is stored with the broadcast value, as if it had been ready.
- R9: `flush` empties every slot at the next edge, and a dispatch presented in the same cycle is dropped.
- R10: After reset the pool is empty: `dispFull` is low and every `issValid` bit is low.
- R11: An issue port presents the opcode, the destination tag and both operand values of the instruction it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all slots |
| dispValid | input | 1 | A dispatch is presented |
| dispUnit | input | 2 | Unit class of the dispatched instruction |
| dispOp | input | OPC_W | Opcode carried through to issue |
| dispDest | input | TAG_W | Destination reorder-buffer tag |
| dispARdy | input | 1 | Operand A holds a value |
| dispATag | input | TAG_W | Producer tag of operand A when pending |
| dispAVal | input | DATA_W | Value of operand A when ready |
| dispBRdy | input | 1 | Operand B holds a value |
| dispBTag | input | TAG_W | Producer tag of operand B when pending |
| dispBVal | input | DATA_W | Value of operand B when ready |
| dispFull | output | 1 | No free slot; dispatch must stall |
| bcValid | input | 4 | Per-unit result broadcast valid |
| bcTag | input | 4 x TAG_W | Per-unit result tag |
| bcData | input | 4 x DATA_W | Per-unit result value |
| unitReady | input | 4 | Per-unit ability to accept an instruction |
| issValid | output | 4 | Per-unit issue strobe |
| issOp | output | 4 x OPC_W | Issued opcode per unit |
| issDest | output | 4 x TAG_W | Issued destination tag per unit |
| issA | output | 4 x DATA_W | Issued operand A per unit |
| issB | output | 4 x DATA_W | Issued operand B per unit |

## Verification
Two pairs of functions can meet in one cycle. A dispatch can meet a result broadcast that it depends on, and a dispatch into a slot can meet the issue that frees that same slot. The bench sets up the first pair by driving a broadcast on the memory bus in the cycle an instruction arrives with that tag pending. It then expects the instruction on its issue port in the very next cycle, carrying the broadcast value. It sets up the second pair by issuing the oldest of four adder instructions while a fifth instruction is presented against a full pool, then dispatching into the freed slot. It judges the result by the order of destination tags on the adder port, which must follow dispatch order and not slot order.

// File: rtl/rsPoolPkg.sv
package rsPoolPkg;
  localparam int ENTRIES = 4;
  localparam int UNITS   = 4;

  typedef enum logic [1:0] {
    UNIT_ADD = 2'd0,
    UNIT_MUL = 2'd1,
    UNIT_DIV = 2'd2,
    UNIT_MEM = 2'd3
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [ENTRIES-1:0]            alloc;
    logic [UNITS-1:0][ENTRIES-1:0] grant;
  } rsStrobe_t;
endpackage

// File: rtl/rsPoolCtrl.sv
module rsPoolCtrl
  import rsPoolPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    dispValid,
  input  logic [1:0]              dispUnit,
  input  logic [UNITS-1:0]        unitReady,
  input  logic [ENTRIES-1:0]      entReady,
  output logic                    dispFull,
  output logic [UNITS-1:0]        issValid,
  output rsStrobe_t               strobe
);
  logic [ENTRIES-1:0]              valid;
  unit_e                           unitOf [ENTRIES];
  // olderThan[i][j] : slot j holds an instruction older than slot i
  logic [ENTRIES-1:0][ENTRIES-1:0] olderThan;
  logic [ENTRIES-1:0]              freeOh;
  logic [ENTRIES-1:0]              issuedMask;
  logic [UNITS-1:0][ENTRIES-1:0]   cand;
  logic                            accept;

  assign dispFull = &valid;
  assign accept   = dispValid && !dispFull && !flush;

  always_comb begin
    freeOh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) freeOh = '0;
      if (!valid[i]) freeOh[i] = 1'b1;
    end
  end

  assign strobe.alloc = accept ? freeOh : '0;

  for (genvar u = 0; u < UNITS; u++) begin : gUnit
    for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
      assign cand[u][i] = valid[i] && entReady[i] && unitReady[u]
                          && (unitOf[i] == unit_e'(u));
      assign strobe.grant[u][i] = cand[u][i] && ((cand[u] & olderThan[i]) == '0);
    end
    assign issValid[u] = |strobe.grant[u];
  end

  always_comb begin
    issuedMask = '0;
    for (int u = 0; u < UNITS; u++) issuedMask |= strobe.grant[u];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid     <= '0;
      olderThan <= '0;
      for (int i = 0; i < ENTRIES; i++) unitOf[i] <= UNIT_ADD;
    end else if (flush) begin
      valid <= '0;
    end else begin
      valid <= (valid & ~issuedMask) | strobe.alloc;
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.alloc[i]) begin
          unitOf[i]    <= unit_e'(dispUnit);
          olderThan[i] <= valid & ~issuedMask;
        end else begin
          olderThan[i] <= olderThan[i] & ~strobe.alloc;
        end
      end
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : gChk
    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strobe.grant[u]));
    for (genvar i = 0; i < ENTRIES; i++) begin : gChkE
      // R3
      grant_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.grant[u][i] |-> (valid[i] && entReady[i] && unitReady[u]));
      // R6
      grant_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.grant[u][i] |=> !valid[i]);
    end
  end

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (valid == '0));

  // R1
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispFull |=> ((valid & ~$past(valid)) == '0));
endmodule

// File: rtl/rsPoolData.sv
module rsPoolData
  import rsPoolPkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rsStrobe_t                    strobe,
  input  logic [OPC_W-1:0]             dispOp,
  input  logic [TAG_W-1:0]             dispDest,
  input  logic                         dispARdy,
  input  logic [TAG_W-1:0]             dispATag,
  input  logic [DATA_W-1:0]            dispAVal,
  input  logic                         dispBRdy,
  input  logic [TAG_W-1:0]             dispBTag,
  input  logic [DATA_W-1:0]            dispBVal,
  input  logic [UNITS-1:0]             bcValid,
  input  logic [UNITS-1:0][TAG_W-1:0]  bcTag,
  input  logic [UNITS-1:0][DATA_W-1:0] bcData,
  output logic [ENTRIES-1:0]           entReady,
  output logic [UNITS-1:0][OPC_W-1:0]  issOp,
  output logic [UNITS-1:0][TAG_W-1:0]  issDest,
  output logic [UNITS-1:0][DATA_W-1:0] issA,
  output logic [UNITS-1:0][DATA_W-1:0] issB
);
  logic [ENTRIES-1:0][OPC_W-1:0]  opQ;
  logic [ENTRIES-1:0][TAG_W-1:0]  destQ, aTagQ, bTagQ;
  logic [ENTRIES-1:0][DATA_W-1:0] aValQ, bValQ;
  logic [ENTRIES-1:0]             aRdyQ, bRdyQ;

  logic [ENTRIES-1:0]             aHit, bHit;
  logic [ENTRIES-1:0][DATA_W-1:0] aBus, bBus;
  logic                           daHit, dbHit;
  logic [DATA_W-1:0]              daBus, dbBus;

  // tag match against all result buses
  always_comb begin
    aHit = '0; bHit = '0; aBus = '0; bBus = '0;
    daHit = 1'b0; dbHit = 1'b0; daBus = '0; dbBus = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (bcValid[u]) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (aTagQ[i] == bcTag[u]) begin aHit[i] = 1'b1; aBus[i] = bcData[u]; end
          if (bTagQ[i] == bcTag[u]) begin bHit[i] = 1'b1; bBus[i] = bcData[u]; end
        end
        if (dispATag == bcTag[u]) begin daHit = 1'b1; daBus = bcData[u]; end
        if (dispBTag == bcTag[u]) begin dbHit = 1'b1; dbBus = bcData[u]; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= '0; destQ <= '0; aTagQ <= '0; bTagQ <= '0;
      aValQ <= '0; bValQ <= '0; aRdyQ <= '0; bRdyQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.alloc[i]) begin
          opQ[i]   <= dispOp;
          destQ[i] <= dispDest;
          aTagQ[i] <= dispATag;
          bTagQ[i] <= dispBTag;
          aRdyQ[i] <= dispARdy || daHit;
          bRdyQ[i] <= dispBRdy || dbHit;
          aValQ[i] <= dispARdy ? dispAVal : daBus;
          bValQ[i] <= dispBRdy ? dispBVal : dbBus;
        end else begin
          if (!aRdyQ[i] && aHit[i]) begin aRdyQ[i] <= 1'b1; aValQ[i] <= aBus[i]; end
          if (!bRdyQ[i] && bHit[i]) begin bRdyQ[i] <= 1'b1; bValQ[i] <= bBus[i]; end
        end
      end
    end
  end

  assign entReady = aRdyQ & bRdyQ;

  // one-hot grant selects the payload for each unit
  always_comb begin
    issOp = '0; issDest = '0; issA = '0; issB = '0;
    for (int u = 0; u < UNITS; u++)
      for (int i = 0; i < ENTRIES; i++)
        if (strobe.grant[u][i]) begin
          issOp[u]   |= opQ[i];
          issDest[u] |= destQ[i];
          issA[u]    |= aValQ[i];
          issB[u]    |= bValQ[i];
        end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : gChk
    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (aRdyQ[i] && !strobe.alloc[i]) |=> (aRdyQ[i] && $stable(aValQ[i])));
  end
endmodule

// File: rtl/rsPool.sv
module rsPool
  import rsPoolPkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         dispValid,
  input  logic [1:0]                   dispUnit,
  input  logic [OPC_W-1:0]             dispOp,
  input  logic [TAG_W-1:0]             dispDest,
  input  logic                         dispARdy,
  input  logic [TAG_W-1:0]             dispATag,
  input  logic [DATA_W-1:0]            dispAVal,
  input  logic                         dispBRdy,
  input  logic [TAG_W-1:0]             dispBTag,
  input  logic [DATA_W-1:0]            dispBVal,
  output logic                         dispFull,
  input  logic [3:0]                   bcValid,
  input  logic [3:0][TAG_W-1:0]        bcTag,
  input  logic [3:0][DATA_W-1:0]       bcData,
  input  logic [3:0]                   unitReady,
  output logic [3:0]                   issValid,
  output logic [3:0][OPC_W-1:0]        issOp,
  output logic [3:0][TAG_W-1:0]        issDest,
  output logic [3:0][DATA_W-1:0]       issA,
  output logic [3:0][DATA_W-1:0]       issB
);
  rsStrobe_t          strobe;
  logic [ENTRIES-1:0] entReady;

  rsPoolCtrl uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .dispValid(dispValid),
    .dispUnit(dispUnit), .unitReady(unitReady), .entReady(entReady),
    .dispFull(dispFull), .issValid(issValid), .strobe(strobe)
  );

  rsPoolData #(.OPC_W(OPC_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dispOp(dispOp), .dispDest(dispDest),
    .dispARdy(dispARdy), .dispATag(dispATag), .dispAVal(dispAVal),
    .dispBRdy(dispBRdy), .dispBTag(dispBTag), .dispBVal(dispBVal),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .entReady(entReady), .issOp(issOp), .issDest(issDest),
    .issA(issA), .issB(issB)
  );
endmodule

// File: tb/rsPool_test.sv
module rsPool_test;
  localparam int OPC_W = 8, TAG_W = 3, DATA_W = 32;

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0, dispValid = 1'b0;
  logic [1:0] dispUnit = '0;
  logic [OPC_W-1:0] dispOp = '0;
  logic [TAG_W-1:0] dispDest = '0, dispATag = '0, dispBTag = '0;
  logic dispARdy = 1'b0, dispBRdy = 1'b0;
  logic [DATA_W-1:0] dispAVal = '0, dispBVal = '0;
  logic dispFull;
  logic [3:0] bcValid = '0, unitReady = '0, issValid;
  logic [3:0][TAG_W-1:0] bcTag = '0, issDest;
  logic [3:0][DATA_W-1:0] bcData = '0, issA, issB;
  logic [3:0][OPC_W-1:0] issOp;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  rsPool #(.OPC_W(OPC_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (.*);

  // unit(2) op(8) dest(3) a(32) b(32)
  localparam logic [76:0] VEC [6] = '{
    {2'd0, 8'h11, 3'd1, 32'd5,          32'd7},
    {2'd1, 8'h22, 3'd2, 32'hDEAD_BEEF,  32'd3},
    {2'd2, 8'h33, 3'd3, 32'd100,        32'hFFFF_FFFF},
    {2'd3, 8'h44, 3'd4, 32'h0,          32'h1234},
    {2'd0, 8'h55, 3'd7, 32'h8000_0000,  32'd1},
    {2'd3, 8'h66, 3'd0, 32'd9,          32'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic disp(input logic [1:0] u, input logic [7:0] op, input logic [2:0] d,
                      input logic ar, input logic [2:0] at, input logic [31:0] av,
                      input logic br, input logic [2:0] bt, input logic [31:0] bv);
    dispValid = 1'b1; dispUnit = u; dispOp = op; dispDest = d;
    dispARdy = ar; dispATag = at; dispAVal = av;
    dispBRdy = br; dispBTag = bt; dispBVal = bv;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    // R10 reset state
    chk(!dispFull && issValid == 0, "R10", {dispFull, issValid}, 0);
    rstN = 1'b1;
    tick();

    // table: ready instruction issues on its own unit with its payload (R2, R11, R6)
    foreach (VEC[k]) begin
      unitReady = 4'hF;
      disp(VEC[k][76:75], VEC[k][74:67], VEC[k][66:64], 1'b1, 3'd0, VEC[k][63:32],
           1'b1, 3'd0, VEC[k][31:0]);
      tick();
      dispValid = 1'b0; #1;
      chk(issValid == (4'b1 << VEC[k][76:75]), "R2", issValid, 4'b1 << VEC[k][76:75]);
      chk(issOp[VEC[k][76:75]] == VEC[k][74:67] && issDest[VEC[k][76:75]] == VEC[k][66:64],
          "R11", {issOp[VEC[k][76:75]], issDest[VEC[k][76:75]]}, VEC[k][74:64]);
      chk(issA[VEC[k][76:75]] == VEC[k][63:32] && issB[VEC[k][76:75]] == VEC[k][31:0],
          "R11", {issA[VEC[k][76:75]], issB[VEC[k][76:75]]}, VEC[k][63:0]);
      tick(); #1;
      chk(issValid == 0 && !dispFull, "R6", {dispFull, issValid}, 0);
    end

    // R1 fill with four adder instructions while the adder is busy
    unitReady = 4'h0;
    for (int d = 0; d < 4; d++) begin
      disp(2'd0, 8'hA0, 3'(d), 1'b1, 3'd0, 32'(d), 1'b1, 3'd0, 32'd0);
      tick();
    end
    dispValid = 1'b0; #1;
    chk(dispFull, "R1", dispFull, 1);
    chk(issValid == 0, "R3", issValid, 0);
    // R1 dispatch against a full pool is dropped; oldest issues meanwhile
    disp(2'd0, 8'hA0, 3'd7, 1'b1, 3'd0, 32'd7, 1'b1, 3'd0, 32'd0);
    unitReady = 4'h1; #1;
    chk(issValid == 4'h1 && issDest[0] == 3'd0, "R5", issDest[0], 0);
    tick();
    dispValid = 1'b0; unitReady = 4'h0; #1;
    chk(!dispFull, "R6", dispFull, 0);
    // R6 freed slot 0 reused by a younger instruction
    disp(2'd0, 8'hA0, 3'd4, 1'b1, 3'd0, 32'd4, 1'b1, 3'd0, 32'd0);
    tick();
    dispValid = 1'b0; unitReady = 4'h1;
    // R5 dispatch order, not slot order; R1 dest 7 never appears
    for (int d = 1; d <= 4; d++) begin
      #1;
      chk(issValid == 4'h1 && issDest[0] == 3'(d), "R5", {issValid, issDest[0]}, {4'h1, 3'(d)});
      tick();
    end
    #1;
    chk(issValid == 0 && !dispFull, "R1", {dispFull, issValid}, 0);

    // R4 four units issue together
    unitReady = 4'h0;
    for (int u = 0; u < 4; u++) begin
      disp(2'(u), 8'hB0, 3'(u), 1'b1, 3'd0, 32'(u + 10), 1'b1, 3'd0, 32'd0);
      tick();
    end
    dispValid = 1'b0; unitReady = 4'hF; #1;
    chk(issValid == 4'hF, "R4", issValid, 4'hF);
    chk(issA[2] == 32'd12 && issDest[3] == 3'd3, "R4", {issA[2], issDest[3]}, {32'd12, 3'd3});
    tick(); #1;
    chk(issValid == 0 && !dispFull, "R4", {dispFull, issValid}, 0);

    // R7 wakeup through a result broadcast
    disp(2'd1, 8'hC0, 3'd6, 1'b0, 3'd5, 32'd0, 1'b1, 3'd0, 32'd2);
    tick();
    dispValid = 1'b0;
    bcValid = 4'b0100; bcTag[2] = 3'd4; bcData[2] = 32'h0BAD; #1;  // wrong tag
    chk(issValid == 0, "R3", issValid, 0);
    tick();
    bcTag[2] = 3'd5; bcData[2] = 32'hCAFE; #1;
    chk(issValid == 0, "R7", issValid, 0);
    tick();
    bcValid = '0; #1;
    chk(issValid == 4'h2 && issA[1] == 32'hCAFE, "R7", {issValid, issA[1]}, {4'h2, 32'hCAFE});
    tick();

    // R8 broadcast in the dispatch cycle
    disp(2'd2, 8'hD0, 3'd1, 1'b1, 3'd0, 32'd8, 1'b0, 3'd6, 32'd0);
    bcValid = 4'b1000; bcTag[3] = 3'd6; bcData[3] = 32'h600D;
    tick();
    dispValid = 1'b0; bcValid = '0; #1;
    chk(issValid == 4'h4 && issB[2] == 32'h600D, "R8", {issValid, issB[2]}, {4'h4, 32'h600D});
    tick();

    // R9 flush empties pool and drops same-cycle dispatch
    unitReady = 4'h0;
    disp(2'd0, 8'hE0, 3'd2, 1'b1, 3'd0, 32'd1, 1'b1, 3'd0, 32'd1);
    tick();
    disp(2'd3, 8'hE1, 3'd3, 1'b1, 3'd0, 32'd1, 1'b1, 3'd0, 32'd1);
    tick();
    disp(2'd1, 8'hE2, 3'd4, 1'b1, 3'd0, 32'd1, 1'b1, 3'd0, 32'd1);
    flush = 1'b1;
    tick();
    dispValid = 1'b0; flush = 1'b0; unitReady = 4'hF; #1;
    chk(issValid == 0 && !dispFull, "R9", {dispFull, issValid}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule